// File: doc/BRIEF.md
# Trap Instruction Capture Register

This block remembers the instruction behind the oldest trap still waiting to be handled. For that instruction it holds the 32-bit encoding, the fetch-queue pointer (a wrap flag plus an index) and the offset within that fetch-queue entry. Candidates come from two places. The decode stage offers a complete instruction record. The CSR unit offers a fault record that the block itself turns into an instruction encoding by concatenating the CSR fields.

In every cycle the block picks the older of the valid candidates. It compares that candidate in program order against the stored entry and replaces the entry only when the candidate is strictly older. A pipeline flush or a read-and-clear request empties the register, and either one overrides any update in the same cycle. The stored entry drives the outputs directly from registers, so a change shows one clock edge after the inputs that caused it.

Both candidate inputs are valid-only streams with no back-pressure: the register samples them in every cycle they are valid, and the source never has to wait. The outputs are plain state, not a handshake.

Top module: `trap_insn_capture`

## Requirements
- R1: After an active-low reset, `out_vld` is 0.
- R2: When the register is empty and no clear is requested, any valid candidate is captured at the next clock edge. All of its fields appear on the outputs.
- R3: Pointer A is older than pointer B when the wrap flags are equal and A's index is smaller, or when the flags differ and A's index is larger. A stored entry is replaced by a candidate with an older pointer and is kept against one with a younger pointer.
- R4: When the pointers are equal, the smaller offset is older. A candidate whose pointer and offset both equal the stored entry's does not replace it.
- R5: When both sources are valid in the same cycle, the older of the two is the one compared against the stored entry. If their pointers and offsets are equal, the decode record is the one used.
- R6: The CSR record's encoding is {csr_addr[11:0], csr_rs[4:0], csr_fn[2:0], csr_rd[4:0], 7'b1110011}, from bit 31 down to bit 0.
- R7: A flush clears `out_vld` at the next edge, even if a candidate is valid in the same cycle.
- R8: A read-and-clear request clears `out_vld` at the next edge, even if a candidate is valid in the same cycle.
- R9: In a cycle with no valid candidate and no clear, every output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Pipeline flush; empties the register |
| rdclr_i | input | 1 | Read-and-clear request; empties the register |
| dec_vld | input | 1 | Decode candidate valid |
| dec_insn | input | 32 | Decode candidate encoding |
| dec_ptr_flag | input | 1 | Decode candidate pointer wrap flag |
| dec_ptr_idx | input | PTR_W | Decode candidate pointer index |
| dec_ofs | input | OFS_W | Decode candidate offset |
| csr_vld | input | 1 | CSR fault record valid |
| csr_addr | input | 12 | CSR address field |
| csr_rs | input | 5 | Source register field |
| csr_fn | input | 3 | Function field |
| csr_rd | input | 5 | Destination register field |
| csr_ptr_flag | input | 1 | CSR record pointer wrap flag |
| csr_ptr_idx | input | PTR_W | CSR record pointer index |
| csr_ofs | input | OFS_W | CSR record offset |
| out_vld | output | 1 | Stored entry valid |
| out_insn | output | 32 | Stored encoding |
| out_ptr_flag | output | 1 | Stored pointer wrap flag |
| out_ptr_idx | output | PTR_W | Stored pointer index |
| out_ofs | output | OFS_W | Stored offset |

## Verification
The assertions assume that the candidate inputs are defined (not X) in every cycle whose valid bit is high. The hold property also assumes that nothing outside the two sources and the two clear inputs is meant to move the register. The bench drives every input from a task just after a clock edge and returns all valid and clear inputs to zero after each edge. This means each candidate is offered for exactly one cycle. The pointer values are chosen so that each wrap-flag case and each tie case is reached on purpose, and no aliasing is left to chance.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int INSN_W = 32;
  localparam int CADDR_W = 12;
  localparam int REG_W = 5;
  localparam int FN_W = 3;
  localparam logic [6:0] SYS_OPC = 7'b1110011;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_DEC  = 2'd1,
    PICK_CSR  = 2'd2
  } pick_e;
endpackage

// File: rtl/tic_age_cmp.sv
module tic_age_cmp #(
  parameter int PTR_W = 6,
  parameter int OFS_W = 4
) (
  input  logic             a_flag,
  input  logic [PTR_W-1:0] a_idx,
  input  logic [OFS_W-1:0] a_ofs,
  input  logic             b_flag,
  input  logic [PTR_W-1:0] b_idx,
  input  logic [OFS_W-1:0] b_ofs,
  output logic             a_older
);
  logic same_ptr;
  logic ptr_older;

  always_comb begin
    same_ptr = (a_flag == b_flag) && (a_idx == b_idx);
    if (a_flag == b_flag) ptr_older = (a_idx < b_idx);
    else                  ptr_older = (a_idx > b_idx);
    a_older = same_ptr ? (a_ofs < b_ofs) : ptr_older;
  end
endmodule

// File: rtl/tic_csr_pack.sv
module tic_csr_pack
  import tic_pkg::*;
(
  input  logic [CADDR_W-1:0] addr,
  input  logic [REG_W-1:0]   rs,
  input  logic [FN_W-1:0]    fn,
  input  logic [REG_W-1:0]   rd,
  output logic [INSN_W-1:0]  insn
);
  // field layout R6
  assign insn = {addr, rs, fn, rd, SYS_OPC};
endmodule

// File: rtl/tic_src_sel.sv
module tic_src_sel
  import tic_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int OFS_W = 4
) (
  input  logic              dec_vld,
  input  logic [INSN_W-1:0] dec_insn,
  input  logic              dec_flag,
  input  logic [PTR_W-1:0]  dec_idx,
  input  logic [OFS_W-1:0]  dec_ofs,
  input  logic              csr_vld,
  input  logic [INSN_W-1:0] csr_insn,
  input  logic              csr_flag,
  input  logic [PTR_W-1:0]  csr_idx,
  input  logic [OFS_W-1:0]  csr_ofs,
  output logic              c_vld,
  output logic [INSN_W-1:0] c_insn,
  output logic              c_flag,
  output logic [PTR_W-1:0]  c_idx,
  output logic [OFS_W-1:0]  c_ofs,
  output pick_e             pick
);
  logic csr_first;

  tic_age_cmp #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_cmp (
    .a_flag (csr_flag), .a_idx (csr_idx), .a_ofs (csr_ofs),
    .b_flag (dec_flag), .b_idx (dec_idx), .b_ofs (dec_ofs),
    .a_older(csr_first)
  );

  // R5: decode wins ties, CSR only when strictly older
  always_comb begin
    if (csr_vld && (!dec_vld || csr_first)) pick = PICK_CSR;
    else if (dec_vld)                       pick = PICK_DEC;
    else                                    pick = PICK_NONE;
  end

  always_comb begin
    c_vld = (pick != PICK_NONE);
    if (pick == PICK_CSR) begin
      c_insn = csr_insn;
      c_flag = csr_flag;
      c_idx  = csr_idx;
      c_ofs  = csr_ofs;
    end else begin
      c_insn = dec_insn;
      c_flag = dec_flag;
      c_idx  = dec_idx;
      c_ofs  = dec_ofs;
    end
  end

  always_comb begin
    if (dec_vld || csr_vld) p_sel_live_r5: assert (pick != PICK_NONE);
  end
endmodule

// File: rtl/tic_entry_reg.sv
module tic_entry_reg
  import tic_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int OFS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [INSN_W-1:0] d_insn,
  input  logic              d_flag,
  input  logic [PTR_W-1:0]  d_idx,
  input  logic [OFS_W-1:0]  d_ofs,
  output logic              q_vld,
  output logic [INSN_W-1:0] q_insn,
  output logic              q_flag,
  output logic [PTR_W-1:0]  q_idx,
  output logic [OFS_W-1:0]  q_ofs
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
    end else if (clr) begin
      q_vld <= 1'b0;
    end else if (take) begin
      q_vld <= 1'b1;
    end
  end

  // payload needs no reset; it is qualified by q_vld
  always_ff @(posedge clk) begin
    if (!clr && take) begin
      q_insn <= d_insn;
      q_flag <= d_flag;
      q_idx  <= d_idx;
      q_ofs  <= d_ofs;
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr) |=> (q_vld && q_insn == $past(d_insn) && q_idx == $past(d_idx)));
endmodule

// File: rtl/trap_insn_capture.sv
module trap_insn_capture
  import tic_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int OFS_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               rdclr_i,
  input  logic               dec_vld,
  input  logic [31:0]        dec_insn,
  input  logic               dec_ptr_flag,
  input  logic [PTR_W-1:0]   dec_ptr_idx,
  input  logic [OFS_W-1:0]   dec_ofs,
  input  logic               csr_vld,
  input  logic [11:0]        csr_addr,
  input  logic [4:0]         csr_rs,
  input  logic [2:0]         csr_fn,
  input  logic [4:0]         csr_rd,
  input  logic               csr_ptr_flag,
  input  logic [PTR_W-1:0]   csr_ptr_idx,
  input  logic [OFS_W-1:0]   csr_ofs,
  output logic               out_vld,
  output logic [31:0]        out_insn,
  output logic               out_ptr_flag,
  output logic [PTR_W-1:0]   out_ptr_idx,
  output logic [OFS_W-1:0]   out_ofs
);
  logic [INSN_W-1:0] csr_insn;
  logic              c_vld;
  logic [INSN_W-1:0] c_insn;
  logic              c_flag;
  logic [PTR_W-1:0]  c_idx;
  logic [OFS_W-1:0]  c_ofs;
  pick_e             pick;
  logic              c_older;
  logic              clr;
  logic              take;

  tic_csr_pack u_pack (
    .addr(csr_addr), .rs(csr_rs), .fn(csr_fn), .rd(csr_rd), .insn(csr_insn)
  );

  tic_src_sel #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_sel (
    .dec_vld (dec_vld), .dec_insn(dec_insn), .dec_flag(dec_ptr_flag),
    .dec_idx (dec_ptr_idx), .dec_ofs(dec_ofs),
    .csr_vld (csr_vld), .csr_insn(csr_insn), .csr_flag(csr_ptr_flag),
    .csr_idx (csr_ptr_idx), .csr_ofs(csr_ofs),
    .c_vld(c_vld), .c_insn(c_insn), .c_flag(c_flag), .c_idx(c_idx),
    .c_ofs(c_ofs), .pick(pick)
  );

  tic_age_cmp #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_age (
    .a_flag(c_flag), .a_idx(c_idx), .a_ofs(c_ofs),
    .b_flag(out_ptr_flag), .b_idx(out_ptr_idx), .b_ofs(out_ofs),
    .a_older(c_older)
  );

  assign clr  = flush_i || rdclr_i;
  assign take = c_vld && (!out_vld || c_older);

  tic_entry_reg #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take),
    .d_insn(c_insn), .d_flag(c_flag), .d_idx(c_idx), .d_ofs(c_ofs),
    .q_vld(out_vld), .q_insn(out_insn), .q_flag(out_ptr_flag),
    .q_idx(out_ptr_idx), .q_ofs(out_ofs)
  );

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !out_vld);

  p_rdclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdclr_i |=> !out_vld);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !rdclr_i && !dec_vld && !csr_vld) |=>
      ($stable(out_vld) && $stable(out_insn) && $stable(out_ptr_idx) && $stable(out_ofs)));

  p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_vld && !flush_i && !rdclr_i && (dec_vld || csr_vld)) |=> out_vld);

  p_keep_younger_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !clr && !c_older) |=> (out_vld && $stable(out_insn) && $stable(out_ptr_idx)));
endmodule

// File: tb/sim_trap_insn_capture.sv
module sim_trap_insn_capture;
  localparam int CLK_P = 10;
  localparam int PW = 6;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 0, rdclr_i = 0;
  logic dec_vld = 0; logic [31:0] dec_insn = 0; logic dec_ptr_flag = 0;
  logic [PW-1:0] dec_ptr_idx = 0; logic [OW-1:0] dec_ofs = 0;
  logic csr_vld = 0; logic [11:0] csr_addr = 0; logic [4:0] csr_rs = 0;
  logic [2:0] csr_fn = 0; logic [4:0] csr_rd = 0; logic csr_ptr_flag = 0;
  logic [PW-1:0] csr_ptr_idx = 0; logic [OW-1:0] csr_ofs = 0;
  logic out_vld; logic [31:0] out_insn; logic out_ptr_flag;
  logic [PW-1:0] out_ptr_idx; logic [OW-1:0] out_ofs;

  int n_chk = 0, n_err = 0;

  trap_insn_capture #(.PTR_W(PW), .OFS_W(OW)) u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_entry(string req, logic [31:0] insn, logic f, int idx, int ofs);
    chk(req, "vld", {31'd0, out_vld}, 32'd1);
    chk(req, "insn", out_insn, insn);
    chk(req, "flag", {31'd0, out_ptr_flag}, {31'd0, f});
    chk(req, "idx", {26'd0, out_ptr_idx}, idx[31:0]);
    chk(req, "ofs", {28'd0, out_ofs}, ofs[31:0]);
  endtask

  task automatic set_dec(logic [31:0] insn, logic f, int idx, int ofs);
    dec_vld = 1; dec_insn = insn; dec_ptr_flag = f;
    dec_ptr_idx = idx[PW-1:0]; dec_ofs = ofs[OW-1:0];
  endtask

  task automatic set_csr(logic [11:0] a, logic [4:0] rs, logic [2:0] fn,
                         logic [4:0] rd, logic f, int idx, int ofs);
    csr_vld = 1; csr_addr = a; csr_rs = rs; csr_fn = fn; csr_rd = rd;
    csr_ptr_flag = f; csr_ptr_idx = idx[PW-1:0]; csr_ofs = ofs[OW-1:0];
  endtask

  // one edge, then return all strobes to idle and settle
  task automatic tick();
    @(posedge clk); #1;
    dec_vld = 0; csr_vld = 0; flush_i = 0; rdclr_i = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (2) @(posedge clk); #1; rst_n = 1;
    chk("R1", "vld", {31'd0, out_vld}, 32'd0);
    tick();
    chk("R1", "vld idle", {31'd0, out_vld}, 32'd0);
  endtask

  task automatic t_fill();
    set_dec(32'h00a00093, 0, 5, 6); tick();
    chk_entry("R2", 32'h00a00093, 0, 5, 6);
  endtask

  task automatic t_same_flag();
    set_dec(32'h11111111, 0, 3, 9); tick();
    chk_entry("R3", 32'h11111111, 0, 3, 9);
    set_dec(32'h22222222, 0, 7, 0); tick();
    chk_entry("R3", 32'h11111111, 0, 3, 9);
  endtask

  task automatic t_wrap();
    set_dec(32'h33333333, 1, 10, 0); tick();      // flags differ, idx larger: older
    chk_entry("R3", 32'h33333333, 1, 10, 0);
    set_dec(32'h44444444, 0, 2, 0); tick();       // flags differ, idx smaller: younger
    chk_entry("R3", 32'h33333333, 1, 10, 0);
    set_dec(32'h55555555, 0, 60, 5); tick();      // flags differ, idx larger: older
    chk_entry("R3", 32'h55555555, 0, 60, 5);
  endtask

  task automatic t_offset();
    set_dec(32'h66666666, 0, 60, 3); tick();
    chk_entry("R4", 32'h66666666, 0, 60, 3);
    set_dec(32'h77777777, 0, 60, 3); tick();      // equal: keep
    chk_entry("R4", 32'h66666666, 0, 60, 3);
    set_dec(32'h88888888, 0, 60, 4); tick();      // larger offset: keep
    chk_entry("R4", 32'h66666666, 0, 60, 3);
  endtask

  task automatic t_hold();
    repeat (3) tick();
    chk_entry("R9", 32'h66666666, 0, 60, 3);
  endtask

  task automatic t_rdclr();
    rdclr_i = 1; set_dec(32'h99999999, 0, 0, 0); tick();
    chk("R8", "vld", {31'd0, out_vld}, 32'd0);
  endtask

  task automatic t_dual();
    logic [31:0] e1, e2;
    e1 = {12'h305, 5'd1, 3'b001, 5'd2, 7'b1110011};
    e2 = {12'h7c0, 5'd31, 3'b110, 5'd17, 7'b1110011};
    set_csr(12'h305, 5'd1, 3'b001, 5'd2, 0, 4, 1);
    set_dec(32'haaaa0001, 0, 4, 6); tick();
    chk_entry("R5 R6", e1, 0, 4, 1);
    flush_i = 1; set_dec(32'haaaa0002, 0, 0, 0); tick();
    chk("R7", "vld", {31'd0, out_vld}, 32'd0);
    set_csr(12'h305, 5'd1, 3'b001, 5'd2, 0, 4, 1);
    set_dec(32'hbbbb0001, 0, 4, 1); tick();        // tie: decode wins
    chk_entry("R5", 32'hbbbb0001, 0, 4, 1);
    set_csr(12'h7c0, 5'd31, 3'b110, 5'd17, 0, 2, 0);
    set_dec(32'hbbbb0002, 0, 9, 0); tick();        // csr older, beats stored
    chk_entry("R5 R6", e2, 0, 2, 0);
    set_csr(12'h001, 5'd0, 3'b010, 5'd0, 0, 3, 0);
    set_dec(32'hbbbb0003, 0, 1, 0); tick();        // dec older, beats stored
    chk_entry("R5", 32'hbbbb0003, 0, 1, 0);
    set_csr(12'h002, 5'd0, 3'b010, 5'd0, 0, 8, 0); tick();
    chk_entry("R3", 32'hbbbb0003, 0, 1, 0);
    flush_i = 1; rdclr_i = 1; tick();
    chk("R7", "vld both", {31'd0, out_vld}, 32'd0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_fill(); t_same_flag(); t_wrap(); t_offset();
        t_hold(); t_rdclr(); t_dual();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule